// File: doc/BRIEF.md
# Selectable-Period Strobe Watchdog

This block watches a strobe line driven by a processor. It asks for a system reset when no falling edge of that strobe arrives within a chosen timeout. The period is measured in ticks of an external time base, and a two-bit code picks one of three periods. With a 1 ms tick, the default parameters give periods of 150, 610 and 1200 ms. The watchdog has no enable. Once a restart pulse from the reset sequencer arms it, only the hold input can stop it. The reset sequencer keeps hold asserted while system reset is active.

The strobe is asynchronous. A capture flop is set directly by the falling strobe edge, so a low pulse much narrower than a clock period still counts. The captured event is then synchronized, turned into a one-cycle kick, and used to clear the capture flop. Each kick reloads the counter. The period code is sampled only on a reload, so changing it never disturbs a count already running. When the count expires, the block raises a one-cycle timeout request and then reloads itself.

Top module: `strobe_wdog`

## Requirements
- R1: After rst_ni is released, timeout_o is low and the counter is idle. No timeout is raised until restart_i arms the watchdog.
- R2: The period code on sel_i maps as follows: 2'b00 gives SHORT_TICKS (150), 2'b10 gives LONG_TICKS (1200), and both 2'b01 and the spare code 2'b11 give MID_TICKS (610).
- R3: With tick_i high on every cycle, timeout_o rises exactly N cycles after the cycle in which restart_i was sampled, where N is the selected period. It stays high for a single cycle.
- R4: Only a high-to-low transition of strobe_i reloads the counter. A strobe held low or held high, and a rising edge, leave the count untouched.
- R5: A low pulse on strobe_i narrower than one clock period is still captured and acts as a reload.
- R6: A falling strobe edge reloads the counter at the third rising clock edge after it (two synchronizer stages plus the reload register). Successive falling edges must be at least 8 clock cycles apart.
- R7: While hold_i is high, the counter is cleared and stopped, and restart_i and strobe edges have no effect. After hold_i falls, the watchdog stays idle until restart_i.
- R8: A change of sel_i during a count does not alter the period in progress. The new code takes effect at the next reload (restart, strobe kick, or the reload after a timeout).
- R9: The count advances only on cycles with tick_i high. With no ticks, no timeout occurs.
- R10: Once armed, the watchdog cannot be turned off except by hold_i. After a timeout it reloads and keeps running, and it repeats the request every period until it is kicked or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse, synchronous to clk_i |
| strobe_i | input | 1 | Asynchronous processor strobe; its falling edge is a kick |
| sel_i | input | 2 | Encoded period select |
| restart_i | input | 1 | Arms the counter from the reset sequencer |
| hold_i | input | 1 | High while system reset is active; clears and stops the counter |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
The assertions rely on a few assumptions about the inputs. tick_i, restart_i, hold_i and sel_i must be synchronous to clk_i. The period parameters must all be larger than one. Falling strobe edges must be spaced far enough apart that the capture flop has cleared before the next edge arrives. The stimulus meets these assumptions by changing every synchronous input on the falling clock edge and by keeping strobe falls dozens of cycles apart. The narrow-pulse case places its whole 5 ns low pulse inside a single clock half-period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_SPARE = 2'b11
  } wdog_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdog_edge_capture.sv
module wdog_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic kick_o
);

  logic                   flag_q;
  logic                   seen_q;
  logic                   flag_clr;
  logic [SYNC_STAGES-1:0] sync_q;

  // capture flop released once the event has crossed into clk_i
  assign flag_clr = seen_q | ~rst_ni;

  always_ff @(negedge strobe_i or posedge flag_clr) begin
    if (flag_clr) flag_q <= 1'b0;
    else          flag_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], flag_q};
      seen_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign kick_o = sync_q[SYNC_STAGES-1] & ~seen_q;

  a_r6_kick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o);

endmodule

// File: rtl/wdog_period_map.sv
module wdog_period_map
  import wdog_pkg::*;
#(
  parameter int SHORT_TICKS = 150,
  parameter int MID_TICKS   = 610,
  parameter int LONG_TICKS  = 1200,
  parameter int CNT_W       = 11
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o
);

  always_comb begin
    unique case (wdog_sel_e'(sel_i))
      SEL_SHORT: limit_o = CNT_W'(SHORT_TICKS);
      SEL_LONG:  limit_o = CNT_W'(LONG_TICKS);
      SEL_MID:   limit_o = CNT_W'(MID_TICKS);
      SEL_SPARE: limit_o = CNT_W'(MID_TICKS);
      default:   limit_o = CNT_W'(MID_TICKS);
    endcase
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             to_q;
  logic             last_tick;

  assign last_tick = (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (hold_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (restart_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        lim_q <= limit_i;
      end else if (run_q) begin
        if (kick_i) begin
          cnt_q <= '0;
          lim_q <= limit_i;
        end else if (tick_i) begin
          if (last_tick) begin
            to_q  <= 1'b1;
            cnt_q <= '0;
            lim_q <= limit_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign timeout_o = to_q;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  a_r3_only_when_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(run_q));

  a_r7_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!run_q && cnt_q == '0 && !timeout_o));

  a_r10_no_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !hold_i) |=> run_q);

  a_r8_limit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !hold_i && !restart_i && !kick_i && !tick_i) |=> $stable(lim_q));

  a_r9_no_tick_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !hold_i && !restart_i && !kick_i && !tick_i) |=> ($stable(cnt_q) && !timeout_o));

  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < lim_q));

endmodule

// File: rtl/strobe_wdog.sv
module strobe_wdog
  import wdog_pkg::*;
#(
  parameter int SHORT_TICKS = 150,
  parameter int MID_TICKS   = 610,
  parameter int LONG_TICKS  = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       strobe_i,
  input  logic [1:0] sel_i,
  input  logic       restart_i,
  input  logic       hold_i,
  output logic       timeout_o
);

  localparam int MAX_TICKS = max3(SHORT_TICKS, MID_TICKS, LONG_TICKS);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             kick;
  logic [CNT_W-1:0] limit;

  wdog_edge_capture #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .kick_o  (kick)
  );

  wdog_period_map #(
    .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS  (MID_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .CNT_W      (CNT_W)
  ) u_map (
    .sel_i  (sel_i),
    .limit_o(limit)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kick_i   (kick),
    .restart_i(restart_i),
    .hold_i   (hold_i),
    .limit_i  (limit),
    .timeout_o(timeout_o)
  );

endmodule

// File: tb/tb_strobe_wdog.sv
`timescale 1ns/1ps
module tb_strobe_wdog;

  localparam int SHORT = 150;
  localparam int MID   = 610;
  localparam int LONG  = 1200;
  localparam int NONE  = -1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       strobe = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       restart = 1'b0;
  logic       hold = 1'b0;
  logic       timeout;

  int total = 0;
  int bad = 0;
  int tick_div = 1;

  strobe_wdog dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .strobe_i (strobe),
    .sel_i    (sel),
    .restart_i(restart),
    .hold_i   (hold),
    .timeout_o(timeout)
  );

  always #10 clk = ~clk;

  initial begin : tick_gen
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      if (tick_div == 0) tick = 1'b0;
      else begin
        tick  = (phase == 0);
        phase = (phase + 1) % tick_div;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles until timeout seen at a falling edge, or NONE within max
  task automatic measure(input int max, output int n);
    n = NONE;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (timeout) begin n = i; break; end
    end
  endtask

  task automatic start_run(input logic [1:0] code);
    hold = 1'b1;
    @(negedge clk);
    hold    = 1'b0;
    restart = 1'b1;
    sel     = code;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(timeout == 1'b0, "R1 reset output", int'(timeout), 0);
    measure(1300, n);
    chk(n == NONE, "R1 idle until restart", n, NONE);
  endtask

  task automatic t_periods();
    int n;
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    int exp [4] = '{SHORT, MID, LONG, MID};
    for (int k = 0; k < 4; k++) begin
      start_run(codes[k]);
      measure(1300, n);
      chk(n == exp[k], "R2 period code", n, exp[k]);
      @(negedge clk);
      chk(timeout == 1'b0, "R3 single-cycle request", int'(timeout), 0);
    end
  endtask

  task automatic t_rearm();
    int n;
    start_run(2'b00);
    measure(300, n);
    chk(n == SHORT, "R3 first timeout", n, SHORT);
    measure(300, n);
    chk(n == SHORT, "R10 keeps running after timeout", n, SHORT);
  endtask

  task automatic t_kick();
    int n;
    start_run(2'b00);
    repeat (50) @(negedge clk);
    strobe = 1'b0;
    measure(300, n);
    chk(n == SHORT + 3, "R6 kick reload latency", n, SHORT + 3);
    measure(300, n);
    chk(n == SHORT, "R4 held low is no kick", n, SHORT);
    strobe = 1'b1;
    measure(300, n);
    chk(n == SHORT, "R4 rising edge is no kick", n, SHORT);
    measure(300, n);
    chk(n == SHORT, "R4 held high is no kick", n, SHORT);
  endtask

  task automatic t_narrow();
    int n;
    start_run(2'b00);
    repeat (30) @(negedge clk);
    #2 strobe = 1'b0;
    #5 strobe = 1'b1;
    measure(300, n);
    chk(n == SHORT + 3, "R5 narrow pulse captured", n, SHORT + 3);
  endtask

  task automatic t_sel_change();
    int n;
    start_run(2'b00);
    repeat (20) @(negedge clk);
    sel = 2'b10;
    measure(300, n);
    chk(n == SHORT - 20, "R8 count in progress kept", n, SHORT - 20);
    measure(1300, n);
    chk(n == LONG, "R8 new code at next reload", n, LONG);
    start_run(2'b01);
    repeat (10) @(negedge clk);
    sel = 2'b00;
    strobe = 1'b0;
    measure(300, n);
    chk(n == SHORT + 3, "R8 kick loads new code", n, SHORT + 3);
    strobe = 1'b1;
  endtask

  task automatic t_hold();
    int n;
    start_run(2'b00);
    repeat (40) @(negedge clk);
    hold = 1'b1;
    measure(20, n);
    restart = 1'b1;
    measure(200, n);
    restart = 1'b0;
    chk(n == NONE, "R7 hold stops counter", n, NONE);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    strobe = 1'b0;
    measure(400, n);
    chk(n == NONE, "R7 idle after hold", n, NONE);
    strobe = 1'b1;
    repeat (20) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    measure(300, n);
    chk(n == SHORT, "R7 restart after hold", n, SHORT);
  endtask

  task automatic t_tick();
    int n;
    tick_div = 0;
    start_run(2'b00);
    measure(400, n);
    chk(n == NONE, "R9 no tick no timeout", n, NONE);
    tick_div = 4;
    start_run(2'b00);
    measure(1000, n);
    chk(n >= 4 * (SHORT - 1) && n <= 4 * SHORT + 4, "R9 counts ticks only", n, 4 * SHORT);
    tick_div = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_periods();
    t_rearm();
    t_kick();
    t_narrow();
    t_sel_change();
    t_hold();
    t_tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule